// File: doc/BRIEF.md
# Fetch Address Sequencer with Two-Deep Return Stack

This block produces the instruction fetch address for a small processor with 12-bit instruction words. It holds the program counter, and on every clock (one instruction cycle) it moves it in one of four ways: a step to the next word, a far jump taken from a 9-bit immediate, a near target built from an 8-bit value (a call or a computed jump through the low address byte), or a return to a saved address. A two-entry return stack sits beside it. The stack has no reset and no overflow or underflow flags. Extra pushes lose the oldest entry, and extra pops keep repeating the deepest entry.

The decoder supplies a 3-bit operation class, the immediate field, the ALU result for low-byte writes and the page preselect bit from the status register. The block returns the fetch address, a one-cycle flush that tells the fetch stage to drop its prefetched word after any change of flow, and the literal that a return places in the working register. The parameter `WORDS` sets the implemented program space to 512 or 1024 words. Every address wraps inside that space. Out of reset the counter points at the last word, so the first sequential step lands on address 0.

Top module: `progctr_top`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the fetch address is WORDS-1 and the flush output is 0.
- R2: Operation codes 0 (step) and 5 to 7 advance the fetch address by one, modulo WORDS, so WORDS-1 is followed by 0.
- R3: Code 1 (jump) loads address bits 8:0 from the immediate and bit 9 from the page input.
- R4: Code 2 (call) loads bits 7:0 from the immediate, and code 4 (low-byte write) loads them from the ALU result. In both cases bit 8 is 0 and bit 9 is the page input.
- R5: A call moves stack level 1 into level 2 and stores the fetch address presented during the call cycle into level 1. After three calls in a row, only the two most recent return addresses remain.
- R6: Code 3 (return) loads the fetch address from level 1 and copies level 2 into level 1. Returns beyond the stack depth keep producing the old level-2 address.
- R7: The literal write enable is 1 exactly in cycles whose code is 3, and the literal output then equals immediate bits 7:0.
- R8: The flush output is 1 in the cycle after any code 1 to 4, and 0 in the cycle after any other code.
- R9: Reset leaves both stack levels unchanged, so returns issued after a reset still reach addresses pushed before it.
- R10: With WORDS = 512, address bit 9 is always 0 and the page input has no effect on the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation class: 0 step, 1 jump, 2 call, 3 return, 4 low-byte write, 5-7 step |
| imm_i | input | 9 | Immediate field of the instruction |
| alu_i | input | 8 | ALU result for a low-byte write |
| page_i | input | 1 | Page preselect bit from the status register |
| fetch_addr_o | output | 10 | Program memory fetch address |
| wlit_o | output | 8 | Literal for the working register on a return |
| wlit_we_o | output | 1 | Write enable for the literal |
| flush_o | output | 1 | Discard the prefetched instruction word |

## Verification
The bench builds two copies of the block that receive the same inputs: one with WORDS = 1024 and one with WORDS = 512. With the larger copy, the page input can set address bit 9, so wrap from 1023 to 0 and page-1 targets can be reached. The smaller copy shows, on the same stimulus, that bit 9 stays 0 and that the counter wraps at 511. A directed phase covers stack overflow, repeated returns and a reset between pushes and pops. A random phase then mixes all eight codes.

// File: rtl/progctr_pkg.sv
package progctr_pkg;

  localparam int PC_W = 10;

  typedef enum logic [2:0] {
    OP_STEP = 3'd0,
    OP_JUMP = 3'd1,
    OP_CALL = 3'd2,
    OP_RET  = 3'd3,
    OP_LOWR = 3'd4
  } pc_op_e;

  // sequential successor inside the implemented space
  function automatic logic [PC_W-1:0] step_addr(input logic [PC_W-1:0] a,
                                                input logic [PC_W-1:0] mask);
    return (a + 1'b1) & mask;
  endfunction

  // far target: nine immediate bits plus the page bit on top
  function automatic logic [PC_W-1:0] far_addr(input logic pg,
                                               input logic [8:0] imm,
                                               input logic [PC_W-1:0] mask);
    return {pg, imm} & mask;
  endfunction

  // near target: eight bits, bit 8 forced low, page bit on top
  function automatic logic [PC_W-1:0] near_addr(input logic pg,
                                                input logic [7:0] lo,
                                                input logic [PC_W-1:0] mask);
    return {pg, 1'b0, lo} & mask;
  endfunction

endpackage

// File: rtl/progctr_next.sv
module progctr_next
  import progctr_pkg::*;
#(
  parameter int unsigned WORDS = 1024
) (
  input  logic [2:0]      op_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic [8:0]      imm_i,
  input  logic [7:0]      alu_i,
  input  logic            page_i,
  input  logic [PC_W-1:0] top_i,
  output logic [PC_W-1:0] nxt_o,
  output logic            push_o,
  output logic            pop_o,
  output logic            redirect_o
);

  localparam logic [PC_W-1:0] MASK     = PC_W'(WORDS - 1);
  localparam bit              HAS_PAGE = (WORDS > 512);

  logic page_eff;
  assign page_eff = page_i & HAS_PAGE;

  always_comb begin
    nxt_o      = step_addr(pc_i, MASK);
    push_o     = 1'b0;
    pop_o      = 1'b0;
    redirect_o = 1'b1;
    case (op_i)
      OP_JUMP: nxt_o = far_addr(page_eff, imm_i, MASK);
      OP_CALL: begin
        nxt_o  = near_addr(page_eff, imm_i[7:0], MASK);
        push_o = 1'b1;
      end
      OP_RET: begin
        nxt_o = top_i & MASK;
        pop_o = 1'b1;
      end
      OP_LOWR: nxt_o = near_addr(page_eff, alu_i, MASK);
      default: redirect_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/progctr_stack.sv
module progctr_stack
  import progctr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_i,
  input  logic            pop_i,
  input  logic [PC_W-1:0] push_val_i,
  output logic [PC_W-1:0] lvl1_o,
  output logic [PC_W-1:0] lvl2_o
);

  logic [PC_W-1:0] lvl1_q, lvl2_q;

  // no reset: contents survive a reset of the counter
  always_ff @(posedge clk) begin
    if (push_i) begin
      lvl2_q <= lvl1_q;
      lvl1_q <= push_val_i;
    end else if (pop_i) begin
      lvl1_q <= lvl2_q;
    end
  end

  assign lvl1_o = lvl1_q;
  assign lvl2_o = lvl2_q;

  p_push_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_i && pop_i));

  p_push_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> (lvl1_o == $past(push_val_i)) && (lvl2_o == $past(lvl1_o)));

  p_pop_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |=> (lvl1_o == $past(lvl2_o)) && $stable(lvl2_o));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_i && !pop_i) |=> $stable(lvl1_o) && $stable(lvl2_o));

endmodule

// File: rtl/progctr_top.sv
module progctr_top
  import progctr_pkg::*;
#(
  parameter int unsigned WORDS = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] op_i,
  input  logic [8:0] imm_i,
  input  logic [7:0] alu_i,
  input  logic       page_i,
  output logic [9:0] fetch_addr_o,
  output logic [7:0] wlit_o,
  output logic       wlit_we_o,
  output logic       flush_o
);

  localparam logic [PC_W-1:0] LAST = PC_W'(WORDS - 1);

  logic [PC_W-1:0] pc_q, pc_nxt, lvl1, lvl2;
  logic            push_ev, pop_ev, redirect_ev, flush_q;

  progctr_next #(.WORDS(WORDS)) u_next (
    .op_i       (op_i),
    .pc_i       (pc_q),
    .imm_i      (imm_i),
    .alu_i      (alu_i),
    .page_i     (page_i),
    .top_i      (lvl1),
    .nxt_o      (pc_nxt),
    .push_o     (push_ev),
    .pop_o      (pop_ev),
    .redirect_o (redirect_ev)
  );

  progctr_stack u_stack (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (push_ev & rst_n),
    .pop_i      (pop_ev & rst_n),
    .push_val_i (pc_q),
    .lvl1_o     (lvl1),
    .lvl2_o     (lvl2)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= LAST;
      flush_q <= 1'b0;
    end else begin
      pc_q    <= pc_nxt;
      flush_q <= redirect_ev;
    end
  end

  assign fetch_addr_o = pc_q;
  assign flush_o      = flush_q;
  assign wlit_o       = imm_i[7:0];
  assign wlit_we_o    = pop_ev;

  p_reset_vec_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (fetch_addr_o == LAST) && !flush_o);

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect_ev |=> fetch_addr_o ==
      (($past(fetch_addr_o) == LAST) ? '0 : $past(fetch_addr_o) + 10'd1));

  p_jump_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_JUMP) |=> (fetch_addr_o[8:0] == $past(imm_i)) &&
      (fetch_addr_o[9] == ((WORDS > 512) && $past(page_i))));

  p_near_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_CALL || op_i == OP_LOWR) |=> !fetch_addr_o[8] &&
      (fetch_addr_o[7:0] == ($past(op_i) == OP_CALL ? $past(imm_i[7:0]) : $past(alu_i))));

  p_ret_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_RET) |=> fetch_addr_o == $past(lvl1));

  p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> flush_o == $past(op_i inside {OP_JUMP, OP_CALL, OP_RET, OP_LOWR}));

  generate
    if (WORDS <= 512) begin : g_small
      p_no_bit9_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_addr_o[9]);
    end
  endgenerate

endmodule

// File: tb/progctr_top_tb_top.sv
module progctr_top_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] op = '0;
  logic [8:0] imm = '0;
  logic [7:0] alu = '0;
  logic       page = 1'b0;

  logic [9:0] addr_a, addr_b;
  logic [7:0] lit_a, lit_b;
  logic       we_a, we_b, fl_a, fl_b;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  progctr_top #(.WORDS(1024)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_i(op), .imm_i(imm), .alu_i(alu), .page_i(page),
    .fetch_addr_o(addr_a), .wlit_o(lit_a), .wlit_we_o(we_a), .flush_o(fl_a));

  progctr_top #(.WORDS(512)) dut512_i (
    .clk(clk), .rst_n(rst_n), .op_i(op), .imm_i(imm), .alu_i(alu), .page_i(page),
    .fetch_addr_o(addr_b), .wlit_o(lit_b), .wlit_we_o(we_b), .flush_o(fl_b));

  // behavioural reference, index 0 = 1024 words, index 1 = 512 words
  int    wsz[2] = '{1024, 512};
  int    mpc[2];
  bit    mpck[2];
  int    s1[2], s2[2];
  bit    k1[2], k2[2];
  bit    mflush;
  string tag[2];

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    if (mpck[0]) chk(tag[0], int'(addr_a), mpc[0]);
    if (mpck[1]) chk(tag[1], int'(addr_b), mpc[1]);
    chk("R8 flush", int'(fl_a), int'(mflush));
    chk("R8 flush/R10", int'(fl_b), int'(mflush));
  endtask

  task automatic model(input int o, input int im, input int al, input bit pg);
    mflush = (o >= 1 && o <= 4);
    for (int c = 0; c < 2; c++) begin
      int base;
      base = (pg && wsz[c] == 1024) ? 512 : 0;
      case (o)
        1: begin mpc[c] = (base + im) % wsz[c]; tag[c] = "R3 jump"; end
        2: begin
          s2[c] = s1[c]; k2[c] = k1[c];
          s1[c] = mpc[c]; k1[c] = mpck[c];
          mpc[c] = base + (im % 256); tag[c] = "R4/R5 call";
        end
        3: begin
          mpc[c] = s1[c]; mpck[c] = k1[c];
          s1[c] = s2[c]; k1[c] = k2[c]; tag[c] = "R6 return";
        end
        4: begin mpc[c] = base + al; tag[c] = "R4 low write"; end
        default: begin mpc[c] = (mpc[c] + 1) % wsz[c]; tag[c] = "R2 step"; end
      endcase
      if (c == 1) tag[c] = {tag[c], " R10"};
    end
  endtask

  task automatic step(input int o, input int im, input int al, input bit pg);
    @(negedge clk);
    compare();
    op = 3'(o); imm = 9'(im); alu = 8'(al); page = pg;
    #1;
    chk("R7 literal enable", int'(we_a), int'(o == 3));
    chk("R7 literal enable R10", int'(we_b), int'(o == 3));
    if (o == 3) begin
      chk("R7 literal value", int'(lit_a), im % 256);
      chk("R7 literal value R10", int'(lit_b), im % 256);
    end
    model(o, im, al, pg);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; op = '0;
    repeat (2) @(negedge clk);
    chk("R1 reset address", int'(addr_a), 1023);
    chk("R1 reset address R10", int'(addr_b), 511);
    rst_n = 1'b1;
    #1;
    chk("R1 reset flush", int'(fl_a), 0);
    chk("R1 reset flush R10", int'(fl_b), 0);
    for (int c = 0; c < 2; c++) begin
      mpc[c] = wsz[c] - 1; mpck[c] = 1'b1; tag[c] = "R1 first step";
    end
    mflush = 1'b0;
    model(0, 0, 0, 1'b0);   // inputs already driven as a step
    for (int c = 0; c < 2; c++) tag[c] = (c == 1) ? "R1 wrap to zero R10" : "R1 wrap to zero";
  endtask

  initial begin
    for (int c = 0; c < 2; c++) begin mpck[c] = 0; k1[c] = 0; k2[c] = 0; end
    do_reset();
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    step(1, 9'h1F0, 0, 1);        // R3 jump, page 1
    step(0, 0, 0, 0);
    step(1, 9'h1FE, 0, 1);        // near top of space
    step(0, 0, 0, 0);             // R2 wrap follows
    step(0, 0, 0, 0);
    step(5, 0, 0, 0);             // R2 unused codes step
    step(6, 0, 0, 1);
    step(7, 0, 0, 0);
    step(2, 9'h1A5, 0, 0);        // R4 bit 8 cleared, R5 push
    step(0, 0, 0, 0);
    step(2, 9'h033, 0, 1);
    step(2, 9'h0C4, 0, 0);        // R5 third call drops oldest
    step(3, 9'h0AB, 0, 0);        // R6 returns
    step(3, 9'h012, 0, 0);
    step(3, 9'h0FE, 0, 0);        // R6 repeats old level 2
    step(4, 0, 8'hC3, 1);         // R4 low write page 1
    step(0, 0, 0, 0);
    step(2, 9'h010, 0, 1);
    step(2, 9'h020, 0, 0);
    do_reset();                   // R9 stack kept across reset
    step(3, 9'h055, 0, 0);
    step(3, 9'h066, 0, 0);
    step(0, 0, 0, 0);
    for (int i = 0; i < 600; i++)
      step($urandom_range(0, 7), $urandom_range(0, 511), $urandom_range(0, 255),
           1'($urandom_range(0, 1)));
    step(0, 0, 0, 0);
    @(negedge clk);
    compare();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

endmodule